// File: doc/BRIEF.md
# PC Card Slot Type Probe Sequencer

This block classifies whatever is plugged into a PC Card slot by running a short electrical probe on the slot's two active-low card-detect pins and two voltage-sense pins. The sense pins are open-drain pads. Their output data is tied low outside the block, so the block controls them only through one output enable per pin. When an enable is on, the pin is pulled to ground. When it is off, the pin floats and is pulled up unless the card grounds it. Some cards tie a detect pin to a sense pin, so pulling one sense pin low and watching which detect pin follows shows how the card is wired. That wiring tells a 16-bit card from a CardBus card.

A probe begins when `start_i` is seen while the block is idle. Every sample is taken at the end of a settling wait. All waits are whole milliseconds, timed by a prescaled counter whose clock-cycles-per-millisecond value is a parameter. The pin inputs pass through a synchronizer before they are decoded.

When a 16-bit or CardBus card is recognised, the block pulses the card reset. The reset is asserted for one interval, then released, and the block waits a recovery interval before it raises `done_o`. For the other outcomes `done_o` rises as soon as the decision is made.

The result codes are:

| Code | Result |
|------|--------|
| 0 | no card |
| 1 | partial insertion |
| 2 | 16-bit card |
| 3 | CardBus card |
| 4 | unknown |

Top module: `pcd_sense_seq`

## Requirements
In the requirements below, T stands for TICKS_PER_MS.

- R1: After reset, both sense enables are off, `done_o` is 0, `card_rst_o` is 0 and `result_o` is 0.
- R2: A start seen while idle turns both sense enables on for exactly SETTLE_MS*T cycles. At the end of that window the detect pins are sampled. If both detect pins read high, the block finishes with code 0.
- R3: If exactly one detect pin reads high at the first sample, the block finishes with code 1 (partial insertion).
- R4: If both detect pins read low at the first sample, both enables go off for SETTLE_MS*T cycles and all four pins are sampled again. The outcome is decided in this order:
  - both sense pins low gives code 2;
  - otherwise, both detect pins low gives code 2;
  - otherwise, both detect pins high gives code 4.
- R5: Exactly one sense pin floats high, with `cd2_ni` high and `cd1_ni` low. The block pulls the floating pin low for SETTLE_MS*T cycles and then checks `cd2_ni`: low gives code 3, high gives code 4. With exactly one sense pin floating and only `cd1_ni` high, the result is code 4 at once.
- R6: Both sense pins float and exactly one detect pin is high. The block pulls only `vs2` low for SETTLE_MS*T cycles and then finishes with code 3, whatever it reads.
- R7: For codes 2 and 3, the reset is held at its asserted level for RST_HOLD_MS*T cycles, then released for RST_WAIT_MS*T cycles, and then `done_o` rises.
  - For a 16-bit card the asserted level is 1 and the released level is 0.
  - For a CardBus card the asserted level is 0 and the released level is 1.
  - `card_rst_o` keeps its last level until the next card is recognised.
- R8: `start_i` is accepted only while idle. It is ignored during a probe, including the cycle in which the last wait ends. On acceptance, `done_o` falls at the same edge.
- R9: Sense enables are on only while a probe samples: both during the first wait, and only the chosen pin during a follow-up drive. Both are off while idle and during the reset pulse.
- R10: `result_o` changes only at the edge where a classification is made, and holds its value while `done_o` is high.
- R11: The pin inputs pass through SYNC_STAGES flops. A level that is stable for the last SYNC_STAGES+1 cycles of a wait is the level that gets decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a probe (accepted while idle) |
| cd1_ni | input | 1 | Card-detect pin 1 level (low = grounded) |
| cd2_ni | input | 1 | Card-detect pin 2 level (low = grounded) |
| vs1_i | input | 1 | Sense pin 1 pad level |
| vs2_i | input | 1 | Sense pin 2 pad level |
| vs1_oe_o | output | 1 | Pull sense pin 1 low when 1 |
| vs2_oe_o | output | 1 | Pull sense pin 2 low when 1 |
| card_rst_o | output | 1 | Card reset line, polarity set by the card type |
| done_o | output | 1 | Probe finished; result valid |
| result_o | output | 3 | Result code (0 none, 1 partial, 2 16-bit, 3 CardBus, 4 unknown) |

## Verification
Two things can land on the same clock edge: a start request and the end of the reset-recovery wait that completes a probe. The bench provokes this by raising `start_i` during the reset hold and keeping it high until `done_o` is seen. The request must be ignored at the finishing edge and accepted at the next one, so `done_o` is high for exactly one cycle and a fresh probe follows. A behavioural model of the slot wiring and the probe sequence judges every cycle of this overlap, and a direct check confirms the one-cycle `done_o` pulse.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_PARTIAL = 3'd1,
    RES_PC16    = 3'd2,
    RES_CARDBUS = 3'd3,
    RES_UNKNOWN = 3'd4
  } pcd_result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DET,
    ST_SENSE,
    ST_FOLLOW,
    ST_HOLD,
    ST_RECOVER
  } pcd_state_e;

  typedef enum logic [1:0] {
    VD_PC16,
    VD_UNKNOWN,
    VD_FOLLOW
  } pcd_verdict_e;

endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign d_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
          stage_q[0] <= d_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end
      assign d_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pcd_ms_timer.sv
module pcd_ms_timer #(
  parameter int TICKS_PER_MS = 50000,
  parameter int MS_W         = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expire_o
);

  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             tick;

  assign tick     = (pre_q == PRE_LAST);
  assign expire_o = tick && (ms_q == MS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      ms_q  <= ms_i;
    end else if (ms_q != '0) begin
      if (tick) begin
        pre_q <= '0;
        ms_q  <= ms_q - MS_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

endmodule

// File: rtl/pcd_sense_decode.sv
module pcd_sense_decode
  import pcd_pkg::*;
(
  input  logic [1:0]   cd_i,      // {cd2, cd1}, 1 = high
  input  logic [1:0]   vs_i,      // {vs2, vs1}, 1 = floating high
  output pcd_verdict_e verdict_o,
  output logic [1:0]   drive_o,   // {vs2_oe, vs1_oe} for follow-up
  output logic         strict_o   // follow-up outcome depends on cd2
);

  always_comb begin
    verdict_o = VD_UNKNOWN;
    drive_o   = 2'b00;
    strict_o  = 1'b0;
    if (vs_i == 2'b00 || cd_i == 2'b00) begin
      verdict_o = VD_PC16;
    end else if (cd_i == 2'b11) begin
      verdict_o = VD_UNKNOWN;
    end else begin
      unique case (vs_i)
        2'b11: begin
          verdict_o = VD_FOLLOW;
          drive_o   = 2'b10;
        end
        2'b01, 2'b10: begin
          if (cd_i == 2'b10) begin
            verdict_o = VD_FOLLOW;
            drive_o   = vs_i;
            strict_o  = 1'b1;
          end
        end
        default: verdict_o = VD_UNKNOWN;
      endcase
    end
  end

endmodule

// File: rtl/pcd_sense_seq.sv
module pcd_sense_seq
  import pcd_pkg::*;
#(
  parameter int TICKS_PER_MS = 50000,
  parameter int SETTLE_MS    = 1,
  parameter int RST_HOLD_MS  = 10,
  parameter int RST_WAIT_MS  = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       cd1_ni,
  input  logic       cd2_ni,
  input  logic       vs1_i,
  input  logic       vs2_i,
  output logic       vs1_oe_o,
  output logic       vs2_oe_o,
  output logic       card_rst_o,
  output logic       done_o,
  output logic [2:0] result_o
);

  localparam int MAX_A  = (SETTLE_MS > RST_HOLD_MS) ? SETTLE_MS : RST_HOLD_MS;
  localparam int MAX_MS = (MAX_A > RST_WAIT_MS) ? MAX_A : RST_WAIT_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  localparam logic [MS_W-1:0] MS_SETTLE = MS_W'(SETTLE_MS);
  localparam logic [MS_W-1:0] MS_HOLD   = MS_W'(RST_HOLD_MS);
  localparam logic [MS_W-1:0] MS_WAIT   = MS_W'(RST_WAIT_MS);

  pcd_state_e  state_q, state_d;
  pcd_result_e result_q, result_d;
  logic        done_q, done_d;
  logic        crst_q, crst_d;
  logic [1:0]  drive_q, drive_d;
  logic        strict_q, strict_d;
  logic        load;
  logic [MS_W-1:0] load_ms;
  logic        expire;
  logic        busy;

  logic [3:0]  pins_s;
  logic [1:0]  cd_s, vs_s;

  pcd_verdict_e verdict;
  logic [1:0]   dec_drive;
  logic         dec_strict;

  pcd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({vs2_i, vs1_i, cd2_ni, cd1_ni}),
    .d_o    (pins_s)
  );

  assign cd_s = pins_s[1:0];
  assign vs_s = pins_s[3:2];

  pcd_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .ms_i     (load_ms),
    .expire_o (expire)
  );

  pcd_sense_decode u_decode (
    .cd_i      (cd_s),
    .vs_i      (vs_s),
    .verdict_o (verdict),
    .drive_o   (dec_drive),
    .strict_o  (dec_strict)
  );

  always_comb begin
    state_d  = state_q;
    result_d = result_q;
    done_d   = done_q;
    crst_d   = crst_q;
    drive_d  = drive_q;
    strict_d = strict_q;
    load     = 1'b0;
    load_ms  = MS_SETTLE;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_DET;
          done_d  = 1'b0;
          load    = 1'b1;
        end
      end
      ST_DET: begin
        if (expire) begin
          if (cd_s == 2'b00) begin
            state_d = ST_SENSE;
            load    = 1'b1;
          end else begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            result_d = (cd_s == 2'b11) ? RES_NONE : RES_PARTIAL;
          end
        end
      end
      ST_SENSE: begin
        if (expire) begin
          unique case (verdict)
            VD_PC16: begin
              state_d  = ST_HOLD;
              result_d = RES_PC16;
              crst_d   = 1'b1;
              load     = 1'b1;
              load_ms  = MS_HOLD;
            end
            VD_FOLLOW: begin
              state_d  = ST_FOLLOW;
              drive_d  = dec_drive;
              strict_d = dec_strict;
              load     = 1'b1;
            end
            default: begin
              state_d  = ST_IDLE;
              done_d   = 1'b1;
              result_d = RES_UNKNOWN;
            end
          endcase
        end
      end
      ST_FOLLOW: begin
        if (expire) begin
          if (strict_q && cd_s[1]) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            result_d = RES_UNKNOWN;
          end else begin
            state_d  = ST_HOLD;
            result_d = RES_CARDBUS;
            crst_d   = 1'b0;
            load     = 1'b1;
            load_ms  = MS_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (expire) begin
          state_d = ST_RECOVER;
          crst_d  = (result_q == RES_CARDBUS);
          load    = 1'b1;
          load_ms = MS_WAIT;
        end
      end
      ST_RECOVER: begin
        if (expire) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_q <= RES_NONE;
      done_q   <= 1'b0;
      crst_q   <= 1'b0;
      drive_q  <= 2'b00;
      strict_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      result_q <= result_d;
      done_q   <= done_d;
      crst_q   <= crst_d;
      drive_q  <= drive_d;
      strict_q <= strict_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign vs1_oe_o   = (state_q == ST_DET) || ((state_q == ST_FOLLOW) && drive_q[0]);
  assign vs2_oe_o   = (state_q == ST_DET) || ((state_q == ST_FOLLOW) && drive_q[1]);
  assign card_rst_o = crst_q;
  assign done_o     = done_q;
  assign result_o   = result_q;

endmodule

// File: rtl/pcd_sense_seq_chk.sv
module pcd_sense_seq_chk
  import pcd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_i,
  input logic       vs1_oe_o,
  input logic       vs2_oe_o,
  input logic       card_rst_o,
  input logic       done_o,
  input logic [2:0] result_o
);

  AST_ENABLES_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!vs1_oe_o && !vs2_oe_o)); // R9

  AST_DONE_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i); // R8

  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i) |=> (busy_i && !done_o)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(result_o))); // R10

  AST_PC16_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == RES_PC16) |-> !card_rst_o); // R7

  AST_CARDBUS_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == RES_CARDBUS) |-> card_rst_o); // R7

  AST_RESULT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o <= RES_UNKNOWN)); // R2

endmodule

bind pcd_sense_seq pcd_sense_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_i     (busy),
  .vs1_oe_o   (vs1_oe_o),
  .vs2_oe_o   (vs2_oe_o),
  .card_rst_o (card_rst_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/pcd_sense_seq_bench.sv
`timescale 1ns/1ps
module pcd_sense_seq_bench;

  localparam int T    = 6;
  localparam int SET  = 1;
  localparam int HOLD = 10;
  localparam int WAIT = 100;

  // slot wiring codes
  localparam logic [1:0] C_GND = 2'd0, C_OPEN = 2'd1, C_VS1 = 2'd2, C_VS2 = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vs1_oe, vs2_oe, card_rst, done;
  logic [2:0] result;
  logic cd1_pad, cd2_pad, vs1_pad, vs2_pad;
  logic [1:0] cdc1 = C_OPEN, cdc2 = C_OPEN, vsc1 = C_OPEN, vsc2 = C_OPEN;

  int vectors = 0;
  int miscompares = 0;
  int fail_prints = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // slot model: sense pads pulled up unless grounded or driven; detect pins may be tied to a sense net
  always_comb begin
    vs1_pad = vs1_oe ? 1'b0 : (vsc1 != C_GND);
    vs2_pad = vs2_oe ? 1'b0 : (vsc2 != C_GND);
    cd1_pad = (cdc1 == C_GND) ? 1'b0 : (cdc1 == C_OPEN) ? 1'b1 : (cdc1 == C_VS1) ? vs1_pad : vs2_pad;
    cd2_pad = (cdc2 == C_GND) ? 1'b0 : (cdc2 == C_OPEN) ? 1'b1 : (cdc2 == C_VS1) ? vs1_pad : vs2_pad;
  end

  pcd_sense_seq #(
    .TICKS_PER_MS(T), .SETTLE_MS(SET), .RST_HOLD_MS(HOLD), .RST_WAIT_MS(WAIT), .SYNC_STAGES(2)
  ) u_pcd_sense_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cd1_ni(cd1_pad), .cd2_ni(cd2_pad), .vs1_i(vs1_pad), .vs2_i(vs2_pad),
    .vs1_oe_o(vs1_oe), .vs2_oe_o(vs2_oe), .card_rst_o(card_rst),
    .done_o(done), .result_o(result)
  );

  // ---------------- reference model ----------------
  int m_state, m_cnt;
  logic [2:0] m_res;
  logic m_done, m_crst, m_strict;
  logic [1:0] m_drive;
  logic s_start, s_cd1, s_cd2, s_vs1, s_vs2;

  task automatic m_finish(input logic [2:0] r);
    m_res = r; m_state = 0; m_done = 1'b1;
  endtask

  task automatic m_hold(input logic [2:0] r);
    m_res = r; m_state = 4; m_cnt = HOLD * T; m_crst = (r == 3'd2);
  endtask

  task automatic m_follow(input logic [1:0] drv, input logic strict);
    m_drive = drv; m_strict = strict; m_state = 3; m_cnt = SET * T;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_res = 3'd0; m_done = 1'b0; m_crst = 1'b0;
      m_drive = 2'b00; m_strict = 1'b0;
    end else if (m_state == 0) begin
      if (s_start) begin m_state = 1; m_cnt = SET * T; m_done = 1'b0; end
    end else if (m_cnt > 1) begin
      m_cnt = m_cnt - 1;
    end else begin
      case (m_state)
        1: if (s_cd1 && s_cd2) m_finish(3'd0);
           else if (!s_cd1 && !s_cd2) begin m_state = 2; m_cnt = SET * T; end
           else m_finish(3'd1);
        2: if (!s_vs1 && !s_vs2) m_hold(3'd2);
           else if (!s_cd1 && !s_cd2) m_hold(3'd2);
           else if (s_cd1 && s_cd2) m_finish(3'd4);
           else if (s_vs1 && s_vs2) m_follow(2'b10, 1'b0);
           else if (s_cd2 && !s_cd1) m_follow(s_vs1 ? 2'b01 : 2'b10, 1'b1);
           else m_finish(3'd4);
        3: if (m_strict && s_cd2) m_finish(3'd4); else m_hold(3'd3);
        4: begin m_state = 5; m_cnt = WAIT * T; m_crst = (m_res == 3'd3); end
        default: begin m_state = 0; m_done = 1'b1; end
      endcase
    end
  end

  task automatic report(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      if (fail_prints < 40) begin
        $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
        fail_prints++;
      end
    end
  endtask

  // per-cycle comparison and input sampling, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      report("R9", "vs1_oe", int'(vs1_oe), int'(m_state == 1 || (m_state == 3 && m_drive[0])));
      report("R9", "vs2_oe", int'(vs2_oe), int'(m_state == 1 || (m_state == 3 && m_drive[1])));
      report("R7", "card_rst", int'(card_rst), int'(m_crst));
      report("R8", "done", int'(done), int'(m_done));
      report("R10", "result", int'(result), int'(m_res));
    end
    s_start = start; s_cd1 = cd1_pad; s_cd2 = cd2_pad; s_vs1 = vs1_pad; s_vs2 = vs2_pad;
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic set_card(input logic [1:0] c1, input logic [1:0] c2,
                          input logic [1:0] v1, input logic [1:0] v2);
    @(posedge clk); #1 cdc1 = c1; cdc2 = c2; vsc1 = v1; vsc2 = v2;
  endtask

  task automatic probe(input string tag, input logic [2:0] exp_res, input bit yank);
    pulse_start();
    if (yank) begin
      // card pulled partway: cd2 goes high while a single sense pin is driven (R11)
      @(negedge clk);
      while (!(vs1_oe ^ vs2_oe)) @(negedge clk);
      @(posedge clk); #1 cdc2 = C_OPEN;
    end
    wait_done();
    report(tag, "final result", int'(result), int'(exp_res));
    if (exp_res == 3'd2) report("R7", "16-bit reset released low", int'(card_rst), 0);
    if (exp_res == 3'd3) report("R7", "CardBus reset released high", int'(card_rst), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired act=hung exp=finished");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    int on_cycles;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    report("R1", "vs1_oe after reset", int'(vs1_oe), 0);
    report("R1", "vs2_oe after reset", int'(vs2_oe), 0);
    report("R1", "done after reset", int'(done), 0);
    report("R1", "card_rst after reset", int'(card_rst), 0);
    report("R1", "result after reset", int'(result), 0);

    // R2 empty slot, with enable window length
    set_card(C_OPEN, C_OPEN, C_OPEN, C_OPEN);
    pulse_start();
    on_cycles = 0;
    @(negedge clk);
    while (!done) begin
      if (vs1_oe && vs2_oe) on_cycles++;
      @(negedge clk);
    end
    report("R2", "enable window cycles", on_cycles, SET * T);
    report("R2", "empty slot result", int'(result), 0);

    // R3 partial insertion, both orientations
    set_card(C_GND, C_OPEN, C_OPEN, C_OPEN);
    probe("R3", 3'd1, 1'b0);
    set_card(C_OPEN, C_GND, C_OPEN, C_OPEN);
    probe("R3", 3'd1, 1'b0);

    // R4 16-bit cards and both-detect-high unknown
    set_card(C_GND, C_GND, C_GND, C_GND);
    probe("R4", 3'd2, 1'b0);
    set_card(C_GND, C_GND, C_OPEN, C_OPEN);
    probe("R4", 3'd2, 1'b0);
    set_card(C_VS1, C_VS2, C_OPEN, C_OPEN);
    probe("R4", 3'd4, 1'b0);
    set_card(C_VS1, C_VS2, C_GND, C_GND);
    probe("R4", 3'd2, 1'b0);

    // R5 one sense pin floating
    set_card(C_GND, C_VS1, C_OPEN, C_GND);
    probe("R5", 3'd3, 1'b0);
    set_card(C_GND, C_VS2, C_GND, C_OPEN);
    probe("R5", 3'd3, 1'b0);
    set_card(C_VS1, C_GND, C_OPEN, C_GND);
    probe("R5", 3'd4, 1'b0);
    set_card(C_GND, C_VS1, C_OPEN, C_GND);
    probe("R11", 3'd4, 1'b1);

    // R6 both sense pins floating
    set_card(C_VS1, C_GND, C_OPEN, C_OPEN);
    probe("R6", 3'd3, 1'b0);
    set_card(C_GND, C_VS2, C_OPEN, C_OPEN);
    probe("R6", 3'd3, 1'b0);

    // R8 start held across the finishing edge of the recovery wait
    set_card(C_GND, C_GND, C_GND, C_GND);
    pulse_start();
    @(negedge clk);
    while (!card_rst) @(negedge clk);
    @(posedge clk); #1 start = 1'b1;
    wait_done();
    @(negedge clk);
    report("R8", "done pulse after start collision", int'(done), 0);
    @(posedge clk); #1 start = 1'b0;
    wait_done();
    report("R8", "re-run result", int'(result), 2);

    // R8 start ignored mid-probe: result still per wiring
    set_card(C_GND, C_VS1, C_OPEN, C_GND);
    pulse_start();
    repeat (3 * T) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done();
    report("R8", "mid-probe start ignored", int'(result), 3);
    repeat (5) @(negedge clk);
    report("R10", "result held while done", int'(result), 3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule